// File: doc/BRIEF.md
# Addressed Slave FIFO Read Port

This block holds four independent word FIFOs and lets an external master pull words out of them over a synchronous read port. Every transfer is timed on one interface clock. The master picks a FIFO with a 2-bit address. An active-low chip select and an active-low read strobe together form a read, and an active-low output enable turns on the drive of the data bus. The bus is modelled as a data value plus a drive-enable output. An empty flag reports on the FIFO that is currently selected.

The word at the head of the selected FIFO is always prefetched. As soon as the output enable goes low, that word is on the bus, before any read strobe. Each clock edge that sees chip select and read strobe both low removes the head word, and the next word shows up after that edge. Holding both strobes low gives a burst with one word per cycle. Internal logic fills the FIFOs through a simple push port. The FIFO address is registered before use, so a change of address takes effect one clock after it is presented.

Top module: `sfifo_rd_port`

## Requirements
- R1: `bus_drive` is 1 exactly while `oe_n` is 0, and 0 while `oe_n` is 1.
- R2: Holding `oe_n` low without a valid read removes no word: `bus_data` and `empty` stay unchanged across the edge.
- R3: While the selected FIFO holds data, `bus_data` shows its oldest word with no read strobe having been given.
- R4: A word is removed only at a rising edge where `cs_n` and `rd_n` are both 0. `rd_n` low with `cs_n` high removes nothing.
- R5: Each valid read advances the selected FIFO by one word. A burst with `cs_n` and `rd_n` held low presents consecutive words N, N+1, N+2 on consecutive cycles.
- R6: `fifo_addr` is registered. The outputs follow a new address from the first clock edge after it is presented, and the old FIFO stays selected until then.
- R7: A read of an empty selected FIFO is ignored, and `empty` stays 1.
- R8: `empty` is 1 when the selected FIFO holds no words. It changes only after a clock edge, including the edge that removes the last word.
- R9: Each FIFO holds DEPTH words. `push_full` reports that the FIFO addressed by `push_sel` is full, and a push to a full FIFO is dropped.
- R10: After reset all FIFOs are empty, FIFO 0 is selected, and `empty` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| push_en | input | 1 | Write one word into the FIFO given by push_sel |
| push_sel | input | 2 | FIFO index for the push |
| push_data | input | DATA_W | Word to store |
| push_full | output | 1 | FIFO given by push_sel is full |
| fifo_addr | input | 2 | FIFO index for the read port |
| cs_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Bus output enable, active low |
| rd_n | input | 1 | Read strobe, active low |
| bus_data | output | DATA_W | Head word of the selected FIFO |
| bus_drive | output | 1 | Data bus is driven |
| empty | output | 1 | Selected FIFO holds no words |

## Verification
The hardest case to reach is an address switch in the cycle between two bursts. For that one cycle the outputs must still describe the old FIFO, and they must describe the new one from the next edge. The stimulus empties FIFO 0 and leaves FIFO 1 filled, then changes the address with the strobes idle. That makes the old and new `empty` values different, so a missing address register shows at the ports. A second case is a FIFO filled past DEPTH and then drained, which shows whether the dropped word ever appears on the bus.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;
    localparam int SEL_W     = 2;
    localparam int NUM_FIFOS = 1 << SEL_W;
    typedef logic [SEL_W-1:0] fsel_t;
endpackage

// File: rtl/sfifo_bank.sv
module sfifo_bank #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic [DATA_W-1:0] push_data_i,
    input  logic              pop_i,
    output logic [DATA_W-1:0] head_o,
    output logic              empty_o,
    output logic              full_o
);
    localparam int AW = $clog2(DEPTH);

    typedef struct packed {
        logic [AW:0] wptr;
        logic [AW:0] rptr;
    } bank_st_t;

    bank_st_t st_d, st_q;
    logic [DATA_W-1:0] mem_q [DEPTH];
    logic do_push, do_pop;

    always_comb begin
        st_d    = st_q;
        empty_o = (st_q.wptr == st_q.rptr);
        full_o  = (st_q.wptr[AW] != st_q.rptr[AW]) &&
                  (st_q.wptr[AW-1:0] == st_q.rptr[AW-1:0]);
        do_push = push_i && !full_o;
        do_pop  = pop_i && !empty_o;
        if (do_push) st_d.wptr = st_q.wptr + 1'b1;
        if (do_pop)  st_d.rptr = st_q.rptr + 1'b1;
        head_o  = mem_q[st_q.rptr[AW-1:0]];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[st_q.wptr[AW-1:0]] <= push_data_i;
    end

    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.wptr - st_q.rptr) <= (AW+1)'(DEPTH));
    p_full_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        full_o && push_i |=> st_q.wptr == $past(st_q.wptr));
    p_pop_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i && !empty_o |=> st_q.rptr == $past(st_q.rptr) + 1'b1);
    p_empty_pop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i && empty_o |=> $stable(st_q.rptr));
endmodule

// File: rtl/sfifo_rd_sel.sv
module sfifo_rd_sel
    import sfifo_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  fsel_t                fifo_addr_i,
    input  logic                 cs_n_i,
    input  logic                 rd_n_i,
    output fsel_t                sel_o,
    output logic [NUM_FIFOS-1:0] pop_o
);
    typedef struct packed {
        fsel_t sel;
    } sel_st_t;

    sel_st_t st_d, st_q;
    logic    rd_valid;

    always_comb begin
        st_d     = st_q;
        st_d.sel = fifo_addr_i;
        rd_valid = !cs_n_i && !rd_n_i;
        sel_o    = st_q.sel;
    end

    for (genvar g = 0; g < NUM_FIFOS; g++) begin : g_pop
        assign pop_o[g] = rd_valid && (st_q.sel == fsel_t'(g));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    p_addr_delay_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> sel_o == $past(fifo_addr_i));
    p_single_pop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pop_o));
endmodule

// File: rtl/sfifo_rd_port.sv
module sfifo_rd_port
    import sfifo_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_en,
    input  logic [1:0]        push_sel,
    input  logic [DATA_W-1:0] push_data,
    output logic              push_full,
    input  logic [1:0]        fifo_addr,
    input  logic              cs_n,
    input  logic              oe_n,
    input  logic              rd_n,
    output logic [DATA_W-1:0] bus_data,
    output logic              bus_drive,
    output logic              empty
);
    fsel_t                sel;
    logic [NUM_FIFOS-1:0] pop_vec, empty_vec, full_vec;
    logic [DATA_W-1:0]    head_vec [NUM_FIFOS];

    sfifo_rd_sel i_sel (
        .clk        (clk),
        .rst_n      (rst_n),
        .fifo_addr_i(fifo_addr),
        .cs_n_i     (cs_n),
        .rd_n_i     (rd_n),
        .sel_o      (sel),
        .pop_o      (pop_vec)
    );

    for (genvar g = 0; g < NUM_FIFOS; g++) begin : g_bank
        sfifo_bank #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_bank (
            .clk        (clk),
            .rst_n      (rst_n),
            .push_i     (push_en && (push_sel == fsel_t'(g))),
            .push_data_i(push_data),
            .pop_i      (pop_vec[g]),
            .head_o     (head_vec[g]),
            .empty_o    (empty_vec[g]),
            .full_o     (full_vec[g])
        );
    end

    always_comb begin
        bus_data  = head_vec[sel];
        empty     = empty_vec[sel];
        bus_drive = !oe_n;
        push_full = full_vec[push_sel];
    end

    p_no_pop_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n || rd_n) |-> pop_vec == '0);
    p_oe_no_pop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n && (cs_n || rd_n) && !push_en && (fifo_addr == sel)
        |=> $stable(bus_data) && $stable(empty));
endmodule

// File: tb/test_sfifo_rd_port.sv
module test_sfifo_rd_port;
    localparam int DW = 16;
    localparam int DEPTH = 8;

    logic clk = 0, rst_n = 0;
    logic push_en = 0, cs_n = 1, oe_n = 1, rd_n = 1;
    logic [1:0] push_sel = 0, fifo_addr = 0;
    logic [DW-1:0] push_data = 0;
    logic push_full, bus_drive, empty;
    logic [DW-1:0] bus_data;

    int n_run = 0, n_fail = 0;
    logic [DW-1:0] refq [4][$];
    logic [1:0] sel_m = 0;

    always #10 clk = ~clk;

    sfifo_rd_port #(.DATA_W(DW), .DEPTH(DEPTH)) i_sfifo_rd_port (
        .clk(clk), .rst_n(rst_n), .push_en(push_en), .push_sel(push_sel),
        .push_data(push_data), .push_full(push_full), .fifo_addr(fifo_addr),
        .cs_n(cs_n), .oe_n(oe_n), .rd_n(rd_n), .bus_data(bus_data),
        .bus_drive(bus_drive), .empty(empty)
    );

    typedef struct packed {
        logic       push;
        logic [1:0] psel;
        logic [15:0] pdata;
        logic [1:0] sel;
        logic       cs_n, oe_n, rd_n;
        logic       chk_d, e_drive, e_empty;
        logic [15:0] e_data;
    } vec_t;

    localparam vec_t VEC [9] = '{
        '{1'b1, 2'd0, 16'hA000, 2'd0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 16'h0},
        '{1'b1, 2'd0, 16'hA001, 2'd0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0},
        '{1'b1, 2'd0, 16'hA002, 2'd0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 16'hA000},
        '{1'b0, 2'd0, 16'h0,    2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 16'hA000},
        '{1'b0, 2'd0, 16'h0,    2'd0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 16'hA001},
        '{1'b0, 2'd0, 16'h0,    2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 16'hA001},
        '{1'b0, 2'd0, 16'h0,    2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 16'hA002},
        '{1'b0, 2'd0, 16'h0,    2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 16'h0},
        '{1'b0, 2'd0, 16'h0,    2'd0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 16'h0}
    };

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(logic p, logic [1:0] ps, logic [DW-1:0] pd,
                        logic [1:0] s, logic c, logic o, logic r);
        @(negedge clk);
        push_en = p; push_sel = ps; push_data = pd;
        fifo_addr = s; cs_n = c; oe_n = o; rd_n = r;
        #2;
    endtask

    task automatic commit();
        bit was_full;
        was_full = refq[push_sel].size() >= DEPTH;
        if (!cs_n && !rd_n && refq[sel_m].size() > 0) void'(refq[sel_m].pop_front());
        if (push_en && !was_full) refq[push_sel].push_back(push_data);
        sel_m = fifo_addr;
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #35 rst_n = 1;
        // R10: reset state
        step(0, 0, 0, 0, 1, 1, 1);
        chk("R10 empty after reset", empty, 1);
        chk("R10 R1 no drive", bus_drive, 0);
        chk("R10 not full", push_full, 0);
        commit();

        // table: single read then burst on FIFO 0 (R1 R3 R5 R8)
        for (int i = 0; i < 9; i++) begin
            step(VEC[i].push, VEC[i].psel, VEC[i].pdata, VEC[i].sel,
                 VEC[i].cs_n, VEC[i].oe_n, VEC[i].rd_n);
            chk($sformatf("R1 drive row %0d", i), bus_drive, VEC[i].e_drive);
            chk($sformatf("R8 empty row %0d", i), empty, VEC[i].e_empty);
            if (VEC[i].chk_d)
                chk($sformatf("R3 R5 data row %0d", i), bus_data, VEC[i].e_data);
            commit();
        end

        // fill FIFO 1 and FIFO 2 while FIFO 0 stays selected
        for (int i = 0; i < 3; i++) begin step(1, 1, 16'hB100 + DW'(i), 0, 1, 1, 1); commit(); end
        for (int i = 0; i < 2; i++) begin step(1, 2, 16'hC200 + DW'(i), 0, 1, 1, 1); commit(); end

        // R6: address switch is delayed by one edge
        step(0, 0, 0, 1, 1, 0, 1);
        chk("R6 old FIFO still selected", empty, 1);
        commit();
        step(0, 0, 0, 1, 1, 0, 1);
        chk("R6 new FIFO selected", empty, 0);
        chk("R3 prefetched head", bus_data, 16'hB100);
        commit();

        // R4: read strobe without chip select
        step(0, 0, 0, 1, 1, 0, 0);
        chk("R4 head before strobe", bus_data, 16'hB100);
        commit();
        step(0, 0, 0, 1, 1, 0, 1);
        chk("R4 no pop without cs", bus_data, 16'hB100);
        commit();
        // R2: output enable alone
        step(0, 0, 0, 1, 1, 0, 1);
        chk("R2 oe only keeps head", bus_data, 16'hB100);
        chk("R2 oe only keeps empty", empty, 0);
        commit();

        // R5: burst of FIFO 1
        for (int i = 0; i < 3; i++) begin
            step(0, 0, 0, 1, 0, 0, 0);
            chk($sformatf("R5 burst FIFO1 word %0d", i), bus_data, refq[1][0]);
            commit();
        end
        step(0, 0, 0, 1, 0, 0, 0);
        chk("R8 empty after last pop", empty, 1);
        commit();
        step(0, 0, 0, 1, 1, 0, 1);
        chk("R7 read on empty ignored", empty, 1);
        commit();

        // address switch between bursts: FIFO 2
        step(0, 0, 0, 2, 1, 0, 1);
        commit();
        for (int i = 0; i < 2; i++) begin
            step(0, 0, 0, 2, 0, 0, 0);
            chk($sformatf("R5 burst FIFO2 word %0d", i), bus_data, 16'hC200 + DW'(i));
            commit();
        end
        step(0, 0, 0, 2, 1, 1, 1);
        chk("R8 FIFO2 drained", empty, 1);
        chk("R1 drive off", bus_drive, 0);
        commit();

        // R9: fill FIFO 3 past DEPTH
        for (int i = 0; i < DEPTH + 1; i++) begin
            step(1, 3, 16'hD300 + DW'(i), 3, 1, 1, 1);
            if (i == DEPTH) chk("R9 full at DEPTH", push_full, 1);
            if (i == DEPTH - 1) chk("R9 not full below DEPTH", push_full, 0);
            commit();
        end
        for (int i = 0; i < DEPTH; i++) begin
            step(0, 0, 0, 3, 0, 0, 0);
            chk($sformatf("R9 drain word %0d", i), bus_data, 16'hD300 + DW'(i));
            commit();
        end
        step(0, 3, 0, 3, 1, 1, 1);
        chk("R9 dropped word absent", empty, 1);
        chk("R9 full cleared", push_full, 0);
        commit();

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule